// File: doc/BRIEF.md
# Outstanding Cache Request Tracker

This block sits between a processor-side port and a cache controller. It records every memory request that has been issued and not yet completed. Requests fall into two classes. Read-class requests are plain loads and instruction fetches. Write-class requests are everything that needs exclusive ownership of a line. Each class has its own small fully associative table, and both tables are keyed by the 64-byte line address.

A new request offered on the accept side gets one of three answers. It is accepted and entered in its class table, or it is refused as aliased because a conflicting request for the same line is still pending, or it is refused as full. An alias counter is kept for each of the four conflict kinds. The completion side names a line and a class. It frees the matching entry and reports the stored request kind and the number of cycles the request spent outstanding. If no such entry exists it raises an error. A scanning watchdog compares the age of each live entry against a threshold and latches a deadlock flag, together with the offending line, the first time an entry grows too old.

Top module: `req_tracker`

## Requirements
- R1: An offered request is answered full (status 2) whenever the outstanding count, after any same-cycle completion, is at least MAX_OUT. This check has priority over all alias checks, and a full answer bumps no alias counter.
- R2: Kind codes 2 to 9 (store, RMW read, RMW write, load-linked, store-conditional, locked RMW read, locked RMW write, flush) are write-class. Codes 0 (load), 1 (instruction fetch) and 10 to 15 are read-class.
- R3: A write-class request whose line has a live read-table entry is answered aliased (status 1), is not entered, and increments cnt_st_ld. No line is ever live in both tables.
- R4: A write-class request whose line has a live write-table entry is answered aliased and increments cnt_st_st.
- R5: A read-class request is aliased and increments cnt_ld_st if its line is live in the write table. Otherwise, if its line is live in the read table, it is aliased and increments cnt_ld_ld.
- R6: A request that passes the alias checks but whose class table has no free entry is answered full.
- R7: A successful completion returns the stored kind and a latency equal to the number of clock edges from the accept edge to the completion edge.
- R8: A completion whose line and class match no live entry sets cmp_err, frees nothing and leaves the outstanding count unchanged.
- R9: outstanding equals the number of live entries in both tables. It rises by one on each accept and falls by one on each successful completion.
- R10: When an accept and a completion arrive in the same cycle, the completion is applied first. Its freed entry and lowered count are visible to the accept decision.
- R11: While entries are live, the watchdog raises dl_flag, with the entry's line on dl_line, once some entry's age reaches DL_THRESH. The flag stays set until reset and is never raised earlier.
- R12: The accept status and the completion results appear on the outputs one clock edge after the input edge, each with a one-cycle valid.
- R13: Address bits 5:0 are ignored. All matching uses the line address only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | New request offered this cycle |
| acc_addr | input | ADDR_W | Byte address of the new request |
| acc_type | input | 4 | Request kind code |
| cmp_valid | input | 1 | Completion presented this cycle |
| cmp_line | input | ADDR_W | Line address of the completion |
| cmp_is_wr | input | 1 | Completion class: 1 write, 0 read |
| acc_rsp_valid | output | 1 | Accept answer valid |
| acc_status | output | 2 | 0 ready, 1 aliased, 2 full |
| cmp_rsp_valid | output | 1 | Completion answer valid |
| cmp_kind | output | 4 | Kind stored with the freed entry |
| cmp_latency | output | TS_W | Cycles the freed entry was outstanding |
| cmp_err | output | 1 | Completion matched no entry |
| outstanding | output | $clog2(RD_DEPTH+WR_DEPTH+1) | Live entry count |
| cnt_st_ld | output | CNT_W | Write-class requests aliased on a read |
| cnt_st_st | output | CNT_W | Write-class requests aliased on a write |
| cnt_ld_st | output | CNT_W | Read-class requests aliased on a write |
| cnt_ld_ld | output | CNT_W | Read-class requests aliased on a read |
| dl_flag | output | 1 | Deadlock detected (sticky) |
| dl_line | output | ADDR_W | Line of the first over-age entry |

## Verification
Every accept and completion answer, the alias counters and the outstanding count are registered once. They are therefore due exactly one edge after the edge that sampled the stimulus. The bench drives on the falling edge and checks all of them on the next falling edge. Latencies are predicted from the bench's own count of rising edges between the accept and the completion. The deadlock flag is due some time between DL_THRESH and DL_THRESH plus the entry count edges after the accept. It is checked as still low just before the lower bound and as set just after the upper bound.

// File: rtl/req_tracker_pkg.sv
package req_tracker_pkg;

    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        RK_LOAD      = 4'd0,
        RK_IFETCH    = 4'd1,
        RK_STORE     = 4'd2,
        RK_RMW_RD    = 4'd3,
        RK_RMW_WR    = 4'd4,
        RK_LINK_LD   = 4'd5,
        RK_COND_ST   = 4'd6,
        RK_LOCK_RD   = 4'd7,
        RK_LOCK_WR   = 4'd8,
        RK_FLUSH     = 4'd9
    } req_kind_e;

    typedef enum logic [1:0] {
        AS_READY = 2'd0,
        AS_ALIAS = 2'd1,
        AS_FULL  = 2'd2
    } acc_stat_e;

endpackage

// File: rtl/rt_classify.sv
module rt_classify
    import req_tracker_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    output logic              is_wr
);

    always_comb begin
        case (kind)
            RK_STORE, RK_RMW_RD, RK_RMW_WR, RK_LINK_LD, RK_COND_ST,
            RK_LOCK_RD, RK_LOCK_WR, RK_FLUSH: is_wr = 1'b1;
            default:                          is_wr = 1'b0;
        endcase
    end

endmodule

// File: rtl/rt_table.sv
module rt_table
    import req_tracker_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int TS_W   = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                lk_line,
    input  logic                             alloc_en,
    input  logic [KIND_W-1:0]                alloc_kind,
    input  logic [TS_W-1:0]                  alloc_ts,
    input  logic                             fr_en,
    input  logic [ADDR_W-1:0]                fr_line,
    output logic                             lk_hit,
    output logic                             has_free,
    output logic                             fr_hit,
    output logic [KIND_W-1:0]                fr_kind,
    output logic [TS_W-1:0]                  fr_ts,
    output logic [DEPTH-1:0]                 ent_vld,
    output logic [DEPTH-1:0][ADDR_W-1:0]     ent_line,
    output logic [DEPTH-1:0][TS_W-1:0]       ent_ts
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]               vld;
        logic [DEPTH-1:0][ADDR_W-1:0]   line;
        logic [DEPTH-1:0][KIND_W-1:0]   kind;
        logic [DEPTH-1:0][TS_W-1:0]     ts;
    } tbl_t;

    tbl_t             tb_q, tb_d;
    logic [IDX_W-1:0] fr_idx, new_idx;
    logic [DEPTH-1:0] vld_after;

    always_comb begin
        fr_hit = 1'b0;
        fr_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (fr_en && !fr_hit && tb_q.vld[i] && tb_q.line[i] == fr_line) begin
                fr_hit = 1'b1;
                fr_idx = IDX_W'(i);
            end
        end

        vld_after = tb_q.vld;
        if (fr_hit) vld_after[fr_idx] = 1'b0;

        lk_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_after[i] && tb_q.line[i] == lk_line) lk_hit = 1'b1;
        end

        has_free = 1'b0;
        new_idx  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!has_free && !vld_after[i]) begin
                has_free = 1'b1;
                new_idx  = IDX_W'(i);
            end
        end

        fr_kind = tb_q.kind[fr_idx];
        fr_ts   = tb_q.ts[fr_idx];

        tb_d     = tb_q;
        tb_d.vld = vld_after;
        if (alloc_en && has_free) begin
            tb_d.vld[new_idx]  = 1'b1;
            tb_d.line[new_idx] = lk_line;
            tb_d.kind[new_idx] = alloc_kind;
            tb_d.ts[new_idx]   = alloc_ts;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign ent_vld  = tb_q.vld;
    assign ent_line = tb_q.line;
    assign ent_ts   = tb_q.ts;

endmodule

// File: rtl/rt_watchdog.sv
module rt_watchdog #(
    parameter int N_ENT  = 8,
    parameter int ADDR_W = 32,
    parameter int TS_W   = 16,
    parameter int THRESH = 1000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [TS_W-1:0]                  now,
    input  logic                             any_out,
    input  logic [N_ENT-1:0]                 ent_vld,
    input  logic [N_ENT-1:0][ADDR_W-1:0]     ent_line,
    input  logic [N_ENT-1:0][TS_W-1:0]       ent_ts,
    output logic                             dl_flag,
    output logic [ADDR_W-1:0]                dl_line
);

    localparam int              PW   = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [PW-1:0]   LAST = PW'(N_ENT - 1);
    localparam logic [TS_W-1:0] TH   = TS_W'(THRESH);

    typedef struct packed {
        logic [PW-1:0]     ptr;
        logic              flag;
        logic [ADDR_W-1:0] line;
    } wd_t;

    wd_t             wd_q, wd_d;
    logic [TS_W-1:0] age;
    logic            old_hit;

    always_comb begin
        age     = now - ent_ts[wd_q.ptr];
        old_hit = any_out && ent_vld[wd_q.ptr] && (age >= TH);

        wd_d = wd_q;
        if (any_out) wd_d.ptr = (wd_q.ptr == LAST) ? '0 : wd_q.ptr + PW'(1);
        if (old_hit && !wd_q.flag) begin
            wd_d.flag = 1'b1;
            wd_d.line = ent_line[wd_q.ptr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign dl_flag = wd_q.flag;
    assign dl_line = wd_q.line;

endmodule

// File: rtl/req_tracker.sv
module req_tracker
    import req_tracker_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINE_OFS  = 6,
    parameter int RD_DEPTH  = 4,
    parameter int WR_DEPTH  = 4,
    parameter int MAX_OUT   = 6,
    parameter int TS_W      = 16,
    parameter int CNT_W     = 16,
    parameter int DL_THRESH = 1000
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         acc_valid,
    input  logic [ADDR_W-1:0]                            acc_addr,
    input  logic [KIND_W-1:0]                            acc_type,
    input  logic                                         cmp_valid,
    input  logic [ADDR_W-1:0]                            cmp_line,
    input  logic                                         cmp_is_wr,
    output logic                                         acc_rsp_valid,
    output logic [1:0]                                   acc_status,
    output logic                                         cmp_rsp_valid,
    output logic [KIND_W-1:0]                            cmp_kind,
    output logic [TS_W-1:0]                              cmp_latency,
    output logic                                         cmp_err,
    output logic [$clog2(RD_DEPTH+WR_DEPTH+1)-1:0]       outstanding,
    output logic [CNT_W-1:0]                             cnt_st_ld,
    output logic [CNT_W-1:0]                             cnt_st_st,
    output logic [CNT_W-1:0]                             cnt_ld_st,
    output logic [CNT_W-1:0]                             cnt_ld_ld,
    output logic                                         dl_flag,
    output logic [ADDR_W-1:0]                            dl_line
);

    localparam int                N_ENT    = RD_DEPTH + WR_DEPTH;
    localparam int                OCC_W    = $clog2(N_ENT + 1);
    localparam logic [OCC_W-1:0]  MAX_OCC  = OCC_W'(MAX_OUT);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << LINE_OFS) - 64'd1);

    typedef struct packed {
        logic [TS_W-1:0]   now;
        logic [OCC_W-1:0]  occ;
        logic              acc_rv;
        logic [1:0]        acc_st;
        logic              cmp_rv;
        logic [KIND_W-1:0] cmp_kd;
        logic [TS_W-1:0]   cmp_lat;
        logic              cmp_er;
        logic [CNT_W-1:0]  c_sl;
        logic [CNT_W-1:0]  c_ss;
        logic [CNT_W-1:0]  c_ls;
        logic [CNT_W-1:0]  c_ll;
    } trk_t;

    trk_t st_q, st_d;

    logic [ADDR_W-1:0] acc_ln, cmp_ln;
    logic              acc_is_wr;
    logic              rd_fr_en, wr_fr_en;
    logic              rd_alloc, wr_alloc;
    logic              rd_lk_hit, wr_lk_hit, rd_free, wr_free;
    logic              rd_fr_hit, wr_fr_hit, freed;
    logic [KIND_W-1:0] rd_fr_kind, wr_fr_kind;
    logic [TS_W-1:0]   rd_fr_ts, wr_fr_ts;
    logic [OCC_W-1:0]  occ_after;
    logic [1:0]        stat;
    logic              any_out;

    logic [RD_DEPTH-1:0]               rd_vld;
    logic [RD_DEPTH-1:0][ADDR_W-1:0]   rd_line;
    logic [RD_DEPTH-1:0][TS_W-1:0]     rd_ts;
    logic [WR_DEPTH-1:0]               wr_vld;
    logic [WR_DEPTH-1:0][ADDR_W-1:0]   wr_line;
    logic [WR_DEPTH-1:0][TS_W-1:0]     wr_ts;

    assign acc_ln   = acc_addr & ~OFS_MASK;
    assign cmp_ln   = cmp_line & ~OFS_MASK;
    assign rd_fr_en = cmp_valid && !cmp_is_wr;
    assign wr_fr_en = cmp_valid && cmp_is_wr;
    assign any_out  = (st_q.occ != '0);

    rt_classify u_cls (
        .kind  (acc_type),
        .is_wr (acc_is_wr)
    );

    rt_table #(.DEPTH(RD_DEPTH), .ADDR_W(ADDR_W), .TS_W(TS_W)) u_rd_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_line    (acc_ln),
        .alloc_en   (rd_alloc),
        .alloc_kind (acc_type),
        .alloc_ts   (st_q.now),
        .fr_en      (rd_fr_en),
        .fr_line    (cmp_ln),
        .lk_hit     (rd_lk_hit),
        .has_free   (rd_free),
        .fr_hit     (rd_fr_hit),
        .fr_kind    (rd_fr_kind),
        .fr_ts      (rd_fr_ts),
        .ent_vld    (rd_vld),
        .ent_line   (rd_line),
        .ent_ts     (rd_ts)
    );

    rt_table #(.DEPTH(WR_DEPTH), .ADDR_W(ADDR_W), .TS_W(TS_W)) u_wr_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_line    (acc_ln),
        .alloc_en   (wr_alloc),
        .alloc_kind (acc_type),
        .alloc_ts   (st_q.now),
        .fr_en      (wr_fr_en),
        .fr_line    (cmp_ln),
        .lk_hit     (wr_lk_hit),
        .has_free   (wr_free),
        .fr_hit     (wr_fr_hit),
        .fr_kind    (wr_fr_kind),
        .fr_ts      (wr_fr_ts),
        .ent_vld    (wr_vld),
        .ent_line   (wr_line),
        .ent_ts     (wr_ts)
    );

    rt_watchdog #(
        .N_ENT  (N_ENT),
        .ADDR_W (ADDR_W),
        .TS_W   (TS_W),
        .THRESH (DL_THRESH)
    ) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .now      (st_q.now),
        .any_out  (any_out),
        .ent_vld  ({wr_vld, rd_vld}),
        .ent_line ({wr_line, rd_line}),
        .ent_ts   ({wr_ts, rd_ts}),
        .dl_flag  (dl_flag),
        .dl_line  (dl_line)
    );

    always_comb begin
        st_d     = st_q;
        st_d.now = st_q.now + TS_W'(1);

        // completion side is resolved first
        freed     = rd_fr_hit || wr_fr_hit;
        occ_after = st_q.occ - OCC_W'(freed);

        st_d.cmp_rv  = cmp_valid;
        st_d.cmp_er  = cmp_valid && !freed;
        st_d.cmp_kd  = '0;
        st_d.cmp_lat = '0;
        if (wr_fr_hit) begin
            st_d.cmp_kd  = wr_fr_kind;
            st_d.cmp_lat = st_q.now - wr_fr_ts;
        end else if (rd_fr_hit) begin
            st_d.cmp_kd  = rd_fr_kind;
            st_d.cmp_lat = st_q.now - rd_fr_ts;
        end

        // accept decision sees the post-completion state
        stat = AS_READY;
        if (occ_after >= MAX_OCC) begin
            stat = AS_FULL;
        end else if (acc_is_wr) begin
            if (rd_lk_hit) begin
                stat = AS_ALIAS;
                if (acc_valid) st_d.c_sl = st_q.c_sl + CNT_W'(1);
            end else if (wr_lk_hit) begin
                stat = AS_ALIAS;
                if (acc_valid) st_d.c_ss = st_q.c_ss + CNT_W'(1);
            end else if (!wr_free) begin
                stat = AS_FULL;
            end
        end else begin
            if (wr_lk_hit) begin
                stat = AS_ALIAS;
                if (acc_valid) st_d.c_ls = st_q.c_ls + CNT_W'(1);
            end else if (rd_lk_hit) begin
                stat = AS_ALIAS;
                if (acc_valid) st_d.c_ll = st_q.c_ll + CNT_W'(1);
            end else if (!rd_free) begin
                stat = AS_FULL;
            end
        end

        rd_alloc = acc_valid && (stat == AS_READY) && !acc_is_wr;
        wr_alloc = acc_valid && (stat == AS_READY) && acc_is_wr;

        st_d.acc_rv = acc_valid;
        st_d.acc_st = acc_valid ? stat : 2'd0;
        st_d.occ    = occ_after + OCC_W'(rd_alloc || wr_alloc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_rsp_valid = st_q.acc_rv;
    assign acc_status    = st_q.acc_st;
    assign cmp_rsp_valid = st_q.cmp_rv;
    assign cmp_kind      = st_q.cmp_kd;
    assign cmp_latency   = st_q.cmp_lat;
    assign cmp_err       = st_q.cmp_er;
    assign outstanding   = st_q.occ;
    assign cnt_st_ld     = st_q.c_sl;
    assign cnt_st_st     = st_q.c_ss;
    assign cnt_ld_st     = st_q.c_ls;
    assign cnt_ld_ld     = st_q.c_ll;

endmodule

// File: rtl/rt_tracker_chk.sv
module rt_tracker_chk #(
    parameter int ADDR_W   = 32,
    parameter int RD_DEPTH = 4,
    parameter int WR_DEPTH = 4,
    parameter int MAX_OUT  = 6,
    parameter int OCC_W    = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             acc_valid,
    input logic                             cmp_valid,
    input logic                             acc_rsp_valid,
    input logic [1:0]                       acc_status,
    input logic [OCC_W-1:0]                 outstanding,
    input logic [RD_DEPTH-1:0]              rd_vld,
    input logic [RD_DEPTH-1:0][ADDR_W-1:0]  rd_line,
    input logic [WR_DEPTH-1:0]              wr_vld,
    input logic [WR_DEPTH-1:0][ADDR_W-1:0]  wr_line,
    input logic                             dl_flag
);

    logic shared;

    always_comb begin
        shared = 1'b0;
        for (int i = 0; i < RD_DEPTH; i++) begin
            for (int j = 0; j < WR_DEPTH; j++) begin
                if (rd_vld[i] && wr_vld[j] && rd_line[i] == wr_line[j]) shared = 1'b1;
            end
        end
    end

    AST_OCC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) == ($countones(rd_vld) + $countones(wr_vld))); // R9

    AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) <= MAX_OUT); // R1

    AST_FULL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !cmp_valid && int'(outstanding) >= MAX_OUT) |=> (acc_status == 2'd2)); // R1

    AST_NO_SHARED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !shared); // R3

    AST_ACC_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (acc_rsp_valid && acc_status != 2'd3)); // R12

    AST_DL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dl_flag |=> dl_flag); // R11

endmodule

bind req_tracker rt_tracker_chk #(
    .ADDR_W   (ADDR_W),
    .RD_DEPTH (RD_DEPTH),
    .WR_DEPTH (WR_DEPTH),
    .MAX_OUT  (MAX_OUT),
    .OCC_W    (OCC_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .cmp_valid     (cmp_valid),
    .acc_rsp_valid (acc_rsp_valid),
    .acc_status    (acc_status),
    .outstanding   (outstanding),
    .rd_vld        (rd_vld),
    .rd_line       (rd_line),
    .wr_vld        (wr_vld),
    .wr_line       (wr_line),
    .dl_flag       (dl_flag)
);

// File: tb/req_tracker_tb_top.sv
`timescale 1ns/1ps
module req_tracker_tb_top;

    localparam int RD  = 4;
    localparam int WR  = 4;
    localparam int MAX = 6;
    localparam int TH  = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [3:0]  acc_type = '0;
    logic        cmp_valid = 1'b0;
    logic [31:0] cmp_line = '0;
    logic        cmp_is_wr = 1'b0;
    logic        acc_rsp_valid, cmp_rsp_valid, cmp_err, dl_flag;
    logic [1:0]  acc_status;
    logic [3:0]  cmp_kind;
    logic [15:0] cmp_latency;
    logic [3:0]  outstanding;
    logic [15:0] cnt_st_ld, cnt_st_st, cnt_ld_st, cnt_ld_ld;
    logic [31:0] dl_line;

    always #10 clk = ~clk;

    req_tracker #(
        .ADDR_W(32), .LINE_OFS(6), .RD_DEPTH(RD), .WR_DEPTH(WR),
        .MAX_OUT(MAX), .TS_W(16), .CNT_W(16), .DL_THRESH(TH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_type(acc_type),
        .cmp_valid(cmp_valid), .cmp_line(cmp_line), .cmp_is_wr(cmp_is_wr),
        .acc_rsp_valid(acc_rsp_valid), .acc_status(acc_status),
        .cmp_rsp_valid(cmp_rsp_valid), .cmp_kind(cmp_kind),
        .cmp_latency(cmp_latency), .cmp_err(cmp_err),
        .outstanding(outstanding),
        .cnt_st_ld(cnt_st_ld), .cnt_st_st(cnt_st_st),
        .cnt_ld_st(cnt_ld_st), .cnt_ld_ld(cnt_ld_ld),
        .dl_flag(dl_flag), .dl_line(dl_line)
    );

    int n_tot = 0;
    int n_fail = 0;
    int edges = 0;
    bit done = 1'b0;

    always @(posedge clk) edges <= edges + 1;

    // bench model of the two tables
    bit          rv[RD];
    logic [31:0] rl[RD];
    int          rk[RD];
    int          re[RD];
    bit          wv[WR];
    logic [31:0] wl[WR];
    int          wk[WR];
    int          we[WR];
    int e_sl = 0, e_ss = 0, e_ls = 0, e_ll = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_tot++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit wr_class(input int k);
        return (k >= 2) && (k <= 9);
    endfunction

    function automatic int mcount();
        int c = 0;
        for (int i = 0; i < RD; i++) c += rv[i];
        for (int i = 0; i < WR; i++) c += wv[i];
        return c;
    endfunction

    task automatic op(input bit av, input logic [31:0] aaddr, input int akind,
                      input bit cv, input logic [31:0] caddr, input bit cwr,
                      input string tag);
        logic [31:0] al = aaddr & ~32'h3f;
        logic [31:0] cl = caddr & ~32'h3f;
        int  opedge = edges + 1;
        int  e_stat = 0;
        bit  e_err = 1'b0;
        int  e_kind = 0;
        int  e_lat = 0;
        bit  hr = 1'b0, hw = 1'b0, fr = 1'b0, fw = 1'b0;
        bit  placed;
        if (cv) begin
            e_err = 1'b1;
            if (cwr) begin
                for (int i = 0; i < WR; i++)
                    if (e_err && wv[i] && wl[i] == cl) begin
                        e_err = 1'b0; e_kind = wk[i]; e_lat = opedge - we[i]; wv[i] = 1'b0;
                    end
            end else begin
                for (int i = 0; i < RD; i++)
                    if (e_err && rv[i] && rl[i] == cl) begin
                        e_err = 1'b0; e_kind = rk[i]; e_lat = opedge - re[i]; rv[i] = 1'b0;
                    end
            end
        end
        if (av) begin
            for (int i = 0; i < RD; i++) begin
                if (rv[i] && rl[i] == al) hr = 1'b1;
                if (!rv[i]) fr = 1'b1;
            end
            for (int i = 0; i < WR; i++) begin
                if (wv[i] && wl[i] == al) hw = 1'b1;
                if (!wv[i]) fw = 1'b1;
            end
            if (mcount() >= MAX) e_stat = 2;
            else if (wr_class(akind)) begin
                if (hr)       begin e_stat = 1; e_sl++; end
                else if (hw)  begin e_stat = 1; e_ss++; end
                else if (!fw) e_stat = 2;
                else begin
                    placed = 1'b0;
                    for (int i = 0; i < WR; i++)
                        if (!placed && !wv[i]) begin
                            placed = 1'b1; wv[i] = 1'b1; wl[i] = al; wk[i] = akind; we[i] = opedge;
                        end
                end
            end else begin
                if (hw)       begin e_stat = 1; e_ls++; end
                else if (hr)  begin e_stat = 1; e_ll++; end
                else if (!fr) e_stat = 2;
                else begin
                    placed = 1'b0;
                    for (int i = 0; i < RD; i++)
                        if (!placed && !rv[i]) begin
                            placed = 1'b1; rv[i] = 1'b1; rl[i] = al; rk[i] = akind; re[i] = opedge;
                        end
                end
            end
        end
        acc_valid = av; acc_addr = aaddr; acc_type = akind[3:0];
        cmp_valid = cv; cmp_line = caddr; cmp_is_wr = cwr;
        @(negedge clk);
        chk({tag, " R12 acc_rsp_valid"}, acc_rsp_valid, av);
        if (av) chk({tag, " status"}, acc_status, e_stat);
        chk({tag, " R12 cmp_rsp_valid"}, cmp_rsp_valid, cv);
        if (cv) begin
            chk({tag, " R8 cmp_err"}, cmp_err, e_err);
            if (!e_err) begin
                chk({tag, " R7 kind"}, cmp_kind, e_kind);
                chk({tag, " R7 latency"}, cmp_latency, e_lat);
            end
        end
        chk({tag, " R9 outstanding"}, outstanding, mcount());
        acc_valid = 1'b0; cmp_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < RD; i++) if (rv[i]) op(0, 0, 0, 1, rl[i], 0, tag);
        for (int i = 0; i < WR; i++) if (wv[i]) op(0, 0, 0, 1, wl[i], 1, tag);
    endtask

    task automatic chk_counters(input string tag);
        chk({tag, " R3 cnt_st_ld"}, cnt_st_ld, e_sl);
        chk({tag, " R4 cnt_st_st"}, cnt_st_st, e_ss);
        chk({tag, " R5 cnt_ld_st"}, cnt_ld_st, e_ls);
        chk({tag, " R5 cnt_ld_ld"}, cnt_ld_ld, e_ll);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tot++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < RD; i++) rv[i] = 1'b0;
        for (int i = 0; i < WR; i++) wv[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("reset R9 outstanding", outstanding, 0);
        chk("reset R12 acc_rsp_valid", acc_rsp_valid, 0);
        chk("reset R11 dl_flag", dl_flag, 0);
        chk_counters("reset");

        // R2 R7 R13: every kind code, varied offsets and latencies
        for (int t = 0; t < 16; t++) begin
            logic [31:0] a = 32'h1000 + 32'(t * 64) + 32'((t * 7) % 64);
            op(1, a, t, 0, 0, 0, "R2 sweep accept");
            repeat (t) @(negedge clk);
            op(0, 0, 0, 1, a + 32'd1, wr_class(t), "R2 R13 sweep complete");
        end

        // R3 R4 R5 R13: alias matrix, first request load or store
        for (int f = 0; f < 2; f++) begin
            for (int b = 0; b < 16; b++) begin
                int first = (f == 0) ? 0 : 2;
                op(1, 32'h2000, first, 0, 0, 0, "alias first");
                op(1, 32'h2000 + 32'((b * 4) % 64), b, 0, 0, 0, "R3 R4 R5 R13 alias second");
                op(0, 0, 0, 1, 32'h2000, wr_class(first), "alias release");
            end
        end
        chk_counters("alias matrix");

        // R1 R10: fill to the limit
        for (int i = 0; i < 4; i++) op(1, 32'h3000 + 32'(i * 64), 0, 0, 0, 0, "fill read");
        op(1, 32'h4000, 2, 0, 0, 0, "fill write");
        op(1, 32'h4040, 9, 0, 0, 0, "fill write");
        op(1, 32'h4080, 2, 0, 0, 0, "R1 full write");
        op(1, 32'h3000, 0, 0, 0, 0, "R1 full over alias");
        op(1, 32'h4080, 2, 1, 32'h3000, 0, "R10 complete then accept");
        op(1, 32'h3040, 2, 1, 32'h3040, 0, "R10 same line freed first");
        op(1, 32'h40c0, 1, 1, 32'h9999000, 1, "R10 failed completion keeps full");
        drain("drain fill");
        chk_counters("after fill");

        // R6: read table exhausted below the limit
        for (int i = 0; i < 4; i++) op(1, 32'h5000 + 32'(i * 64), 1, 0, 0, 0, "table fill");
        op(1, 32'h5100, 0, 0, 0, 0, "R6 read table full");
        op(1, 32'h5140, 3, 0, 0, 0, "R6 write still fits");
        // R8: bad completions
        op(0, 0, 0, 1, 32'h7000, 0, "R8 unknown line");
        op(0, 0, 0, 1, 32'h5000, 1, "R8 wrong class");
        drain("drain table");
        chk("R11 no early flag", dl_flag, 0);

        // R11: deadlock watchdog
        op(1, 32'h9000, 0, 0, 0, 0, "R11 stuck accept");
        repeat (TH - 2) @(negedge clk);
        chk("R11 flag before threshold", dl_flag, 0);
        repeat (RD + WR + 4) @(negedge clk);
        chk("R11 flag after threshold", dl_flag, 1);
        chk("R11 flag line", dl_line, 32'h9000);
        drain("drain stuck");
        @(negedge clk);
        chk("R11 flag sticky", dl_flag, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

endmodule